// File: doc/BRIEF.md
# Dual-Page TLB Lookup Unit

This block is a fully associative address translation cache. It maps a 32-bit virtual address to a physical address. It holds a fixed set of entries, and each entry covers two neighbouring 4 KiB pages. The first page of the pair sits where virtual address bit 12 is zero and the second where it is one. Each of the two pages has its own frame number, valid flag and dirty (writable) flag.

All entries are searched together. An entry takes part in a lookup when three conditions hold:
- its tag equals virtual bits 31:13;
- it is global, or its stored address-space identifier equals the current one;
- the address lies below the entry's end bound.

The half selected by bit 12 then decides the outcome. A usable page gives a hit and a translated address. A cleared valid flag reports an invalid page. A write to a page whose dirty flag is clear reports a clean-page write.

Lookup is purely combinational. Entries are loaded through a single write port that updates one entry at a clock edge. Choosing which entry to replace, and raising any exception from the result code, is left to the surrounding logic.

Top module: `dual_page_tlb`

## Requirements
- R1: After reset every entry holds zero in all fields, including an end bound of 0. Every lookup therefore reports miss until entries are written.
- R2: An entry can match only when its stored tag equals virtual address bits 31:13.
- R3: An entry can match only when its global flag is 1 or its stored identifier equals `cur_asid`.
- R4: An entry can match only when the full 32-bit virtual address is strictly below that entry's end bound (unsigned).
- R5: Virtual address bit 12 selects the half of the matched entry: 0 selects the even frame, valid and dirty, and 1 selects the odd ones.
- R6: On a hit, `pa` equals {selected frame number (20 bits), virtual bits 11:0}. On any other result `pa` is 0.
- R7: The result is hit (`result` = 2'b00) when the selected half is valid, and either the access is a read or the selected dirty flag is 1.
- R8: The result is invalid (2'b10) when the selected half's valid flag is 0. This holds for reads and writes alike.
- R9: The result is clean-page write (2'b11) when the selected half is valid, its dirty flag is 0 and `lk_write` is 1.
- R10: The result is miss (2'b01) when no entry matches. In that case `hit_idx` is 0.
- R11: When several entries match, the lowest-numbered one decides the result, and its number is reported on `hit_idx`.
- R12: A write sets the addressed entry at the rising clock edge where `wr_en` is 1. A lookup in the same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all entries |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 for a store access, 0 for a load |
| cur_asid | input | 8 | Current address-space identifier |
| wr_en | input | 1 | Load one entry at this edge |
| wr_idx | input | 4 | Entry number to load |
| wr_tag | input | 19 | Virtual tag (address bits 31:13) |
| wr_asid | input | 8 | Identifier stored in the entry |
| wr_global | input | 1 | Entry matches any identifier |
| wr_end | input | 32 | Exclusive upper bound of addresses the entry covers |
| wr_pfn_even | input | 20 | Frame number of the even page |
| wr_v_even | input | 1 | Even page valid |
| wr_d_even | input | 1 | Even page writable |
| wr_pfn_odd | input | 20 | Frame number of the odd page |
| wr_v_odd | input | 1 | Odd page valid |
| wr_d_odd | input | 1 | Odd page writable |
| pa | output | 32 | Translated physical address (0 unless hit) |
| result | output | 2 | 00 hit, 01 miss, 10 invalid, 11 clean-page write |
| hit_idx | output | 4 | Number of the deciding entry (0 on miss) |

## Verification
The bench builds the block with its default of 16 entries. That is few enough to fill every slot and then sweep 17 identifier values against 18 tags, both page halves, both access kinds and four page offsets. The sweep brings every combination of valid and dirty flags, global and private entries, a bound that splits an odd page, and a duplicated tag matched by two entries into reach. A further step rewrites an entry to show that the old contents stay visible until the clock edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Address layout
  localparam int VA_W    = 32;
  localparam int OFS_W   = 12;
  localparam int TAG_LSB = OFS_W + 1;
  localparam int TAG_W   = VA_W - TAG_LSB;
  localparam int PFN_W   = VA_W - OFS_W;
  localparam int ASID_W  = 8;

  typedef enum logic [1:0] {
    RES_HIT     = 2'b00,
    RES_MISS    = 2'b01,
    RES_INVALID = 2'b10,
    RES_CLEAN   = 2'b11
  } tlb_res_e;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             v;
    logic             d;
  } page_half_t;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ASID_W-1:0] asid;
    logic              g;
    logic [VA_W-1:0]   end_b;
    page_half_t [1:0]  half;
  } tlb_entry_t;

  function automatic logic [TAG_W-1:0] tag_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:TAG_LSB];
  endfunction

  function automatic logic half_of(input logic [VA_W-1:0] va);
    return va[OFS_W];
  endfunction

  function automatic logic [VA_W-1:0] phys_of(input logic [PFN_W-1:0] pfn,
                                              input logic [VA_W-1:0]  va);
    return {pfn, va[OFS_W-1:0]};
  endfunction

  function automatic logic entry_hits(input tlb_entry_t        e,
                                      input logic [VA_W-1:0]   va,
                                      input logic [ASID_W-1:0] asid);
    logic id_ok;
    id_ok = e.g | (e.asid == asid);
    return id_ok && (e.tag == tag_of(va)) && (va < e.end_b);
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  tlb_entry_t               wr_entry,
  output tlb_entry_t [ENTRIES-1:0] ents
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic load_here;
    assign load_here = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ents[e] <= '0;
      end else if (load_here) begin
        ents[e] <= wr_entry;
      end
    end
  end

endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  tlb_entry_t [ENTRIES-1:0] ents,
  input  logic [VA_W-1:0]          va,
  input  logic [ASID_W-1:0]        asid,
  output logic [ENTRIES-1:0]       match_vec
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = entry_hits(ents[e], va, asid);
  end

endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  tlb_entry_t [ENTRIES-1:0] ents,
  input  logic [ENTRIES-1:0]       match_vec,
  input  logic [VA_W-1:0]          va,
  input  logic                     is_write,
  output tlb_res_e                 res,
  output logic [VA_W-1:0]          pa,
  output logic [IDX_W-1:0]         idx,
  output logic                     sel_v,
  output logic                     sel_d
);

  logic       found;
  tlb_entry_t win;
  page_half_t half;

  // Lowest-numbered match wins: scan downward so the last assignment is the lowest.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  assign win   = ents[idx];
  assign half  = win.half[half_of(va)];
  assign sel_v = found & half.v;
  assign sel_d = found & half.d;

  always_comb begin
    pa = '0;
    if (!found) begin
      res = RES_MISS;
    end else if (!half.v) begin
      res = RES_INVALID;
    end else if (is_write && !half.d) begin
      res = RES_CLEAN;
    end else begin
      res = RES_HIT;
      pa  = phys_of(half.pfn, va);
    end
  end

endmodule

// File: rtl/dual_page_tlb.sv
module dual_page_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       lk_vaddr,
  input  logic              lk_write,
  input  logic [7:0]        cur_asid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [18:0]       wr_tag,
  input  logic [7:0]        wr_asid,
  input  logic              wr_global,
  input  logic [31:0]       wr_end,
  input  logic [19:0]       wr_pfn_even,
  input  logic              wr_v_even,
  input  logic              wr_d_even,
  input  logic [19:0]       wr_pfn_odd,
  input  logic              wr_v_odd,
  input  logic              wr_d_odd,
  output logic [31:0]       pa,
  output logic [1:0]        result,
  output logic [IDX_W-1:0]  hit_idx
);

  tlb_entry_t [ENTRIES-1:0] ents;
  tlb_entry_t               wr_entry;
  logic [ENTRIES-1:0]       match_vec;
  tlb_res_e                 res;
  logic                     sel_v;
  logic                     sel_d;

  always_comb begin
    wr_entry            = '0;
    wr_entry.tag        = wr_tag;
    wr_entry.asid       = wr_asid;
    wr_entry.g          = wr_global;
    wr_entry.end_b      = wr_end;
    wr_entry.half[0].pfn = wr_pfn_even;
    wr_entry.half[0].v  = wr_v_even;
    wr_entry.half[0].d  = wr_d_even;
    wr_entry.half[1].pfn = wr_pfn_odd;
    wr_entry.half[1].v  = wr_v_odd;
    wr_entry.half[1].d  = wr_d_odd;
  end

  tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_entry (wr_entry),
    .ents     (ents)
  );

  tlb_match #(.ENTRIES(ENTRIES)) u_match (
    .ents      (ents),
    .va        (lk_vaddr),
    .asid      (cur_asid),
    .match_vec (match_vec)
  );

  tlb_resolve #(.ENTRIES(ENTRIES)) u_resolve (
    .ents      (ents),
    .match_vec (match_vec),
    .va        (lk_vaddr),
    .is_write  (lk_write),
    .res       (res),
    .pa        (pa),
    .idx       (hit_idx),
    .sel_v     (sel_v),
    .sel_d     (sel_d)
  );

  assign result = res;

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [31:0]        lk_vaddr,
  input logic               lk_write,
  input logic [31:0]        pa,
  input logic [1:0]         result,
  input logic [IDX_W-1:0]   hit_idx,
  input logic [ENTRIES-1:0] match_vec,
  input logic               sel_v,
  input logic               sel_d
);

  logic [ENTRIES-1:0] below_mask;
  always_comb below_mask = (ENTRIES'(1) << hit_idx) - ENTRIES'(1);

  // R6
  hit_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result == 2'b00) |-> (pa[11:0] == lk_vaddr[11:0]));

  // R6
  nonhit_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result != 2'b00) |-> (pa == 32'd0));

  // R10
  miss_when_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((result == 2'b01) == (match_vec == '0)));

  // R11
  lowest_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result != 2'b01) |-> (match_vec[hit_idx] && ((match_vec & below_mask) == '0)));

  // R8
  invalid_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result == 2'b10) |-> !sel_v);

  // R9
  clean_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result == 2'b11) |-> (lk_write && sel_v && !sel_d));

  // R7
  store_hit_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((result == 2'b00) && lk_write) |-> sel_d);

endmodule

bind dual_page_tlb tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_vaddr  (lk_vaddr),
  .lk_write  (lk_write),
  .pa        (pa),
  .result    (result),
  .hit_idx   (hit_idx),
  .match_vec (match_vec),
  .sel_v     (sel_v),
  .sel_d     (sel_d)
);

// File: tb/sim_dual_page_tlb.sv
module sim_dual_page_tlb;

  localparam int N = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_vaddr = 0;
  logic        lk_write = 0;
  logic [7:0]  cur_asid = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_idx = 0;
  logic [18:0] wr_tag = 0;
  logic [7:0]  wr_asid = 0;
  logic        wr_global = 0;
  logic [31:0] wr_end = 0;
  logic [19:0] wr_pfn_even = 0, wr_pfn_odd = 0;
  logic        wr_v_even = 0, wr_d_even = 0, wr_v_odd = 0, wr_d_odd = 0;
  logic [31:0] pa;
  logic [1:0]  result;
  logic [3:0]  hit_idx;

  always #5 clk = ~clk;

  dual_page_tlb u0 (.*);

  // Bench model of the entries
  logic [18:0] m_tag [N];
  logic [7:0]  m_asid[N];
  logic        m_g   [N];
  logic [31:0] m_end [N];
  logic [19:0] m_pfn [N][2];
  logic        m_v   [N][2];
  logic        m_d   [N][2];

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_tag[i] = 0; m_asid[i] = 0; m_g[i] = 0; m_end[i] = 0;
      for (int h = 0; h < 2; h++) begin
        m_pfn[i][h] = 0; m_v[i][h] = 0; m_d[i][h] = 0;
      end
    end
  endtask

  task automatic load(input int i, input logic [18:0] t, input logic [7:0] a,
                      input logic g, input logic [31:0] e,
                      input logic [19:0] p0, input logic v0, input logic d0,
                      input logic [19:0] p1, input logic v1, input logic d1);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(i); wr_tag = t; wr_asid = a; wr_global = g; wr_end = e;
    wr_pfn_even = p0; wr_v_even = v0; wr_d_even = d0;
    wr_pfn_odd = p1; wr_v_odd = v1; wr_d_odd = d1;
    @(posedge clk);
    #1 wr_en = 0;
    m_tag[i] = t; m_asid[i] = a; m_g[i] = g; m_end[i] = e;
    m_pfn[i][0] = p0; m_v[i][0] = v0; m_d[i][0] = d0;
    m_pfn[i][1] = p1; m_v[i][1] = v1; m_d[i][1] = d1;
  endtask

  // Expected outcome restated from the requirements
  task automatic expect_of(input logic [31:0] va, input logic w, input logic [7:0] asid,
                           output logic [1:0] r, output logic [31:0] p, output logic [3:0] ix,
                           output string req);
    int  win = -1;
    int  nmatch = 0;
    int  hf;
    for (int i = 0; i < N; i++) begin
      if ((m_g[i] || m_asid[i] == asid) && m_tag[i] == va[31:13] && va < m_end[i]) begin
        nmatch++;
        if (win < 0) win = i;
      end
    end
    r = 2'b01; p = 0; ix = 0; req = "R10";
    if (win >= 0) begin
      ix = 4'(win);
      hf = va[12] ? 1 : 0;
      if (!m_v[win][hf]) begin
        r = 2'b10; req = "R8";
      end else if (w && !m_d[win][hf]) begin
        r = 2'b11; req = "R9";
      end else begin
        r = 2'b00; p = {m_pfn[win][hf], va[11:0]}; req = hf ? "R5/R7" : "R7";
      end
      if (nmatch > 1) req = {req, " R11"};
    end
  endtask

  task automatic probe(input logic [31:0] va, input logic w, input logic [7:0] asid,
                       input string tag_req);
    logic [1:0] er; logic [31:0] ep; logic [3:0] ei; string rq;
    @(negedge clk);
    lk_vaddr = va; lk_write = w; cur_asid = asid;
    #2;
    expect_of(va, w, asid, er, ep, ei, rq);
    if (tag_req != "") rq = tag_req;
    n_checks++;
    if (result !== er || pa !== ep || hit_idx !== ei) begin
      n_fail++;
      $display("FAIL %s va=%h w=%0d asid=%h: got res=%b pa=%h idx=%0d, exp res=%b pa=%h idx=%0d",
               rq, va, w, asid, result, pa, hit_idx, er, ep, ei);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: nothing matches after reset, even tag 0 / asid 0
    probe(32'h0000_0000, 0, 8'h00, "R1");
    probe(32'h0000_1ABC, 1, 8'h00, "R1");
    probe(32'hFFFF_F000, 0, 8'hFF, "R1");

    // Fill all entries; entry 12 duplicates tag 3 as a global entry (R11)
    for (int i = 0; i < N; i++) begin
      logic [18:0] t;
      logic [31:0] e;
      t = (i == 12) ? 19'd3 : 19'(i + 1);
      e = (i == 5) ? ((32'(t) << 13) + 32'h1800) : 32'hFFFF_FFFF;
      load(i, t, 8'(i), (i % 4) == 0, e,
           20'(32'h100 + 2*i), (i % 3) != 0, (i % 2) == 0,
           20'(32'h100 + 2*i + 1), (i % 5) != 1, (i % 3) == 1);
    end

    // Sweep: R2 tags, R3 identifiers, R4 bound (entry 5), R5 halves, R6-R11 results
    for (int a = 0; a < 17; a++) begin
      for (int t = 0; t < 18; t++) begin
        for (int h = 0; h < 2; h++) begin
          for (int w = 0; w < 2; w++) begin
            for (int o = 0; o < 4; o++) begin
              logic [11:0] ofs;
              logic [31:0] va;
              ofs = (o == 0) ? 12'h000 : (o == 1) ? 12'h7FF : (o == 2) ? 12'h800 : 12'hFFF;
              va  = (32'(t) << 13) | (32'(h) << 12) | 32'(ofs);
              probe(va, w[0], (a == 16) ? 8'hFF : 8'(a), "");
            end
          end
        end
      end
    end

    // R4: bound is exclusive at exactly end
    probe(32'h0000_D800, 0, 8'h05, "R4");
    probe(32'h0000_D7FF, 0, 8'h05, "R4");

    // R12: during the write cycle the old entry still answers
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd0; wr_tag = 19'h7FFFF; wr_asid = 8'h00; wr_global = 1;
    wr_end = 32'hFFFF_FFFF; wr_pfn_even = 20'hABCDE; wr_v_even = 1; wr_d_even = 1;
    wr_pfn_odd = 20'h12345; wr_v_odd = 1; wr_d_odd = 1;
    lk_vaddr = 32'hFFFF_E123; lk_write = 1; cur_asid = 8'h09;
    #2;
    n_checks++;
    if (result !== 2'b01) begin
      n_fail++;
      $display("FAIL R12 same-cycle: got res=%b, exp res=01", result);
    end
    @(posedge clk);
    #1 wr_en = 0;
    m_tag[0] = 19'h7FFFF; m_g[0] = 1; m_end[0] = 32'hFFFF_FFFF;
    m_pfn[0][0] = 20'hABCDE; m_v[0][0] = 1; m_d[0][0] = 1;
    m_pfn[0][1] = 20'h12345; m_v[0][1] = 1; m_d[0][1] = 1;
    probe(32'hFFFF_E123, 1, 8'h09, "R12");
    probe(32'hFFFF_F456, 0, 8'h09, "R12");
    // old tag 1 mapping in entry 0 is gone
    probe(32'h0000_2000, 0, 8'h00, "R12");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule